// File: doc/BRIEF.md
# Host Bus Command and Status Port

This block sits between an 8-bit microcontroller bus and the serial transmitter and receiver of an asynchronous communication controller. It turns chip-select, command/data-select, read and write strobes into single-cycle actions. These actions are pushes into the transmit queue, pops from the receive queue, command writes and status reads. It does not build or parse serial frames itself.

Command bytes set the frame options, the block length, the enables and request-to-send, the wakeup mode and address, the interrupt polarity and two general output pins. Some command bytes announce that the next command byte is a value rather than a new command. The internal-reset and error-reset bits act only as one-cycle pulses and are never stored. The block also holds the divider that produces the 16x sample tick. Its interrupt pin is driven from the serial engine's flags with a polarity that software selects. Successive status reads return two different status words in turn.

Top module: `host_bus_if`

## Requirements
- R1: An access needs cs_n low with exactly one of rd_n and wr_n low. cd=0 selects queue data and cd=1 selects command/status. If cs_n is high, or if rd_n and wr_n are both low, nothing happens and dout_oe stays low. dout_oe is high only during a valid read.
- R2: Each strobe acts once, in its first clock cycle, however long it is held. In that cycle tx_push (with tx_data = din) or rx_pop is high for one cycle. The byte read appears on dout from the next cycle on.
- R3: A command byte is decoded by bits 7:6. 00 sets the frame: bit0 prescale 32, bit1 divider byte follows, bit2 two stop bits, bit3 CRC, bit4 parity, bit5 even parity. 01 loads the block length from bits 5:0. 10 is control. 11 sets the pins: bit2 interrupt polarity, bit1 route packet-done to p1, bit0 p0 level.
- R4: cfg_crc_en is high only when CRC is selected and parity is not; parity takes priority.
- R5: A frame byte with bit1 set makes the next command byte the divider value n. A control byte with bit2 set turns on wakeup mode and makes the next command byte the local address. Such a pending byte is taken as a value whatever its bits 7:6 are. Data writes and reads in between do not use up the pending slot.
- R6: In a control byte, bit3 drives rts_n low, bit1 sets rx_en and bit0 sets tx_en.
- R7: A control byte with bit5 set returns every command setting to its reset value, drops any pending byte, restarts the divider and the status alternation, and ignores the byte's other bits. soft_rst is high for exactly the one cycle after that write.
- R8: A control byte with bit4 set applies its other bits and gives a one-cycle err_clr pulse in the cycle after the write. Nothing of bit4 is kept.
- R9: baud_tick is high for one cycle every P*(n+1) clocks, where P is 2 when frame bit0 is 0 and 32 when it is 1. Loading n restarts the count.
- R10: Status reads alternate. The first after reset or internal reset returns {0, crc err, parity err, overrun, framing err, tx buffer empty, rx full, rx packet end}. The next returns {1, 000, tx idle, packet sent, wakeup held, wakeup mode}. Data reads do not change the alternation.
- R11: The interrupt request is tx buffer empty OR rx full OR rx packet end. irq is registered from the request and from the polarity setting as they stood before the clock edge: active-high when polarity is 1, active-low when 0.
- R12: p0 follows pin bit0. p1 equals st_tx_pkt_done when pin bit1 is set and equals p0 otherwise.
- R13: After reset all settings are 0, so rts_n=1, irq=1, n=0 and P=2, and dout_oe, tx_push, rx_pop, soft_rst and err_clr are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| cd | input | 1 | 1 = command/status, 0 = queue data |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| din | input | 8 | Bus write data |
| dout | output | 8 | Bus read data |
| dout_oe | output | 1 | Drive enable for dout |
| tx_push | output | 1 | Push tx_data into transmit queue |
| tx_data | output | 8 | Byte for transmit queue |
| rx_pop | output | 1 | Pop receive queue head |
| rx_data | input | 8 | Receive queue head byte |
| st_crc_err | input | 1 | CRC error flag |
| st_par_err | input | 1 | Parity error flag |
| st_ovr_err | input | 1 | Overrun flag |
| st_frm_err | input | 1 | Framing error flag |
| st_tx_buf_empty | input | 1 | Transmit queue empty |
| st_rx_full | input | 1 | Receive queue full |
| st_rx_pkt_end | input | 1 | Receive packet complete |
| st_tx_idle | input | 1 | Transmitter holds no characters |
| st_tx_pkt_done | input | 1 | Packet transmission complete |
| st_wake_held | input | 1 | Wakeup currently held |
| cfg_two_stop | output | 1 | Two stop bits |
| cfg_even_par | output | 1 | Even parity |
| cfg_par_en | output | 1 | Parity enable |
| cfg_crc_en | output | 1 | CRC enable (after parity priority) |
| cfg_blk_len | output | 6 | Block length m |
| tx_en | output | 1 | Transmit enable |
| rx_en | output | 1 | Receive enable |
| wake_mode | output | 1 | Wakeup mode |
| wake_addr | output | 8 | Local wakeup address |
| soft_rst | output | 1 | Internal reset pulse |
| err_clr | output | 1 | Error flag clear pulse |
| baud_tick | output | 1 | 16x sample tick |
| rts_n | output | 1 | Request to send, active low |
| p0 | output | 1 | General output pin |
| p1 | output | 1 | General output or packet-done |
| irq | output | 1 | Interrupt with selectable polarity |

## Verification
Two things can change at the same edge: the interrupt polarity, through a pin command write, and the interrupt request, through a flag. The bench raises a receive-full flag at the very clock edge where the write strobe carrying the new polarity arrives. It then checks that irq shows the new request under the old polarity for one cycle and the new polarity after that, so the line never reads inactive between the two. A second overlap is a pending divider byte whose bits look like an internal reset. It must load n and must not produce a soft_rst pulse.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
  localparam int BYTE_W = 8;
  localparam int BLK_W  = 6;

  typedef enum logic [1:0] {
    OP_FRAME = 2'b00,
    OP_BLEN  = 2'b01,
    OP_CTRL  = 2'b10,
    OP_PINS  = 2'b11
  } hbi_op_e;

  typedef enum logic [1:0] {
    PND_NONE = 2'd0,
    PND_BAUD = 2'd1,
    PND_ADDR = 2'd2
  } hbi_pend_e;

  // all-zero is the reset value of every setting
  typedef struct packed {
    logic [BYTE_W-1:0] baud_n;
    logic              pre32;
    logic              two_stop;
    logic              even;
    logic              par_en;
    logic              crc_sel;
    logic [BLK_W-1:0]  blk_len;
    logic              tx_en;
    logic              rx_en;
    logic              rts_on;
    logic              wake_mode;
    logic [BYTE_W-1:0] wake_addr;
    logic              irq_pol;
    logic              p1_route;
    logic              p0;
  } hbi_cfg_t;
endpackage

// File: rtl/hbi_strobe.sv
module hbi_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic rd_n,
  input  logic wr_n,
  output logic rd_ev,
  output logic wr_ev,
  output logic rd_on
);
  logic rd_act, wr_act;
  logic rd_q, wr_q;

  // both strobes low is not a valid access
  assign rd_act = ~cs_n & ~rd_n & wr_n;
  assign wr_act = ~cs_n & ~wr_n & rd_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= 1'b0;
      wr_q <= 1'b0;
    end else begin
      rd_q <= rd_act;
      wr_q <= wr_act;
    end
  end

  assign rd_ev = rd_act & ~rd_q;
  assign wr_ev = wr_act & ~wr_q;
  assign rd_on = rd_act;
endmodule

// File: rtl/hbi_cmd.sv
module hbi_cmd
  import hbi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ev,
  input  logic              cd,
  input  logic [BYTE_W-1:0] din,
  output hbi_cfg_t          cfg,
  output logic              baud_load,
  output logic              clr_now,
  output logic              soft_rst,
  output logic              err_clr
);
  hbi_cfg_t  cfg_q, cfg_d;
  hbi_pend_e pend_q, pend_d;
  logic      sr_q, sr_d, ec_q, ec_d;
  logic      cmd_ev;
  hbi_op_e   op;

  assign cmd_ev = wr_ev & cd;
  assign op     = hbi_op_e'(din[7:6]);

  always_comb begin
    cfg_d     = cfg_q;
    pend_d    = pend_q;
    sr_d      = 1'b0;
    ec_d      = 1'b0;
    baud_load = 1'b0;
    clr_now   = 1'b0;
    if (cmd_ev) begin
      case (pend_q)
        PND_BAUD: begin
          cfg_d.baud_n = din;
          pend_d       = PND_NONE;
          baud_load    = 1'b1;
        end
        PND_ADDR: begin
          cfg_d.wake_addr = din;
          pend_d          = PND_NONE;
        end
        default: begin
          case (op)
            OP_FRAME: begin
              cfg_d.pre32    = din[0];
              cfg_d.two_stop = din[2];
              cfg_d.crc_sel  = din[3];
              cfg_d.par_en   = din[4];
              cfg_d.even     = din[5];
              if (din[1]) pend_d = PND_BAUD;
            end
            OP_BLEN: cfg_d.blk_len = din[BLK_W-1:0];
            OP_CTRL: begin
              if (din[5]) begin
                cfg_d   = '0;
                pend_d  = PND_NONE;
                sr_d    = 1'b1;
                clr_now = 1'b1;
              end else begin
                ec_d            = din[4];
                cfg_d.rts_on    = din[3];
                cfg_d.wake_mode = din[2];
                cfg_d.rx_en     = din[1];
                cfg_d.tx_en     = din[0];
                if (din[2]) pend_d = PND_ADDR;
              end
            end
            default: begin
              cfg_d.irq_pol  = din[2];
              cfg_d.p1_route = din[1];
              cfg_d.p0       = din[0];
            end
          endcase
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      pend_q <= PND_NONE;
      sr_q   <= 1'b0;
      ec_q   <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      pend_q <= pend_d;
      sr_q   <= sr_d;
      ec_q   <= ec_d;
    end
  end

  assign cfg      = cfg_q;
  assign soft_rst = sr_q;
  assign err_clr  = ec_q;
endmodule

// File: rtl/hbi_baud.sv
module hbi_baud #(
  parameter int PRE_LO = 2,
  parameter int PRE_HI = 32,
  parameter int DIV_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             pre32,
  input  logic [DIV_W-1:0] div_n,
  output logic             tick
);
  localparam int PC_W = $clog2(PRE_HI);

  logic [PC_W-1:0]  pc_q, pc_d, pre_top;
  logic [DIV_W-1:0] dc_q, dc_d;
  logic             tick_q, tick_d;
  logic             pre_hit, div_hit;

  assign pre_top = pre32 ? PC_W'(PRE_HI - 1) : PC_W'(PRE_LO - 1);
  assign pre_hit = (pc_q >= pre_top);
  assign div_hit = (dc_q >= div_n);

  always_comb begin
    pc_d   = pc_q;
    dc_d   = dc_q;
    tick_d = 1'b0;
    if (restart) begin
      pc_d = '0;
      dc_d = '0;
    end else begin
      pc_d = pre_hit ? '0 : pc_q + 1'b1;
      if (pre_hit) begin
        dc_d   = div_hit ? '0 : dc_q + 1'b1;
        tick_d = div_hit;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      dc_q   <= '0;
      tick_q <= 1'b0;
    end else begin
      pc_q   <= pc_d;
      dc_q   <= dc_d;
      tick_q <= tick_d;
    end
  end

  assign tick = tick_q;
endmodule

// File: rtl/host_bus_if.sv
module host_bus_if
  import hbi_pkg::*;
#(
  parameter int PRE_LO = 2,
  parameter int PRE_HI = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              cd,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] dout,
  output logic              dout_oe,
  output logic              tx_push,
  output logic [BYTE_W-1:0] tx_data,
  output logic              rx_pop,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              st_crc_err,
  input  logic              st_par_err,
  input  logic              st_ovr_err,
  input  logic              st_frm_err,
  input  logic              st_tx_buf_empty,
  input  logic              st_rx_full,
  input  logic              st_rx_pkt_end,
  input  logic              st_tx_idle,
  input  logic              st_tx_pkt_done,
  input  logic              st_wake_held,
  output logic              cfg_two_stop,
  output logic              cfg_even_par,
  output logic              cfg_par_en,
  output logic              cfg_crc_en,
  output logic [BLK_W-1:0]  cfg_blk_len,
  output logic              tx_en,
  output logic              rx_en,
  output logic              wake_mode,
  output logic [BYTE_W-1:0] wake_addr,
  output logic              soft_rst,
  output logic              err_clr,
  output logic              baud_tick,
  output logic              rts_n,
  output logic              p0,
  output logic              p1,
  output logic              irq
);
  logic [1:0]        rs_q;
  logic              rst_i_n;
  logic              rd_ev, wr_ev, rd_on;
  logic              baud_load, clr_now;
  hbi_cfg_t          cfg;
  logic              sel2_q, sel2_d;
  logic [BYTE_W-1:0] dout_q, dout_d;
  logic              irq_q, irq_d;
  logic              irq_req;
  logic [BYTE_W-1:0] st1, st2;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  hbi_strobe u_strobe (
    .clk   (clk),
    .rst_n (rst_i_n),
    .cs_n  (cs_n),
    .rd_n  (rd_n),
    .wr_n  (wr_n),
    .rd_ev (rd_ev),
    .wr_ev (wr_ev),
    .rd_on (rd_on)
  );

  hbi_cmd u_cmd (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .wr_ev     (wr_ev),
    .cd        (cd),
    .din       (din),
    .cfg       (cfg),
    .baud_load (baud_load),
    .clr_now   (clr_now),
    .soft_rst  (soft_rst),
    .err_clr   (err_clr)
  );

  hbi_baud #(
    .PRE_LO (PRE_LO),
    .PRE_HI (PRE_HI),
    .DIV_W  (BYTE_W)
  ) u_baud (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .restart (baud_load | clr_now),
    .pre32   (cfg.pre32),
    .div_n   (cfg.baud_n),
    .tick    (baud_tick)
  );

  assign st1 = {1'b0, st_crc_err, st_par_err, st_ovr_err, st_frm_err,
                st_tx_buf_empty, st_rx_full, st_rx_pkt_end};
  assign st2 = {1'b1, 3'b000, st_tx_idle, st_tx_pkt_done, st_wake_held,
                cfg.wake_mode};
  assign irq_req = st_tx_buf_empty | st_rx_full | st_rx_pkt_end;

  always_comb begin
    sel2_d = sel2_q;
    dout_d = dout_q;
    irq_d  = cfg.irq_pol ? irq_req : ~irq_req;
    if (clr_now)          sel2_d = 1'b0;
    else if (rd_ev && cd) sel2_d = ~sel2_q;
    if (rd_ev) dout_d = cd ? (sel2_q ? st2 : st1) : rx_data;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      sel2_q <= 1'b0;
      dout_q <= '0;
      irq_q  <= 1'b1;
    end else begin
      sel2_q <= sel2_d;
      dout_q <= dout_d;
      irq_q  <= irq_d;
    end
  end

  assign dout         = dout_q;
  assign dout_oe      = rd_on;
  assign tx_push      = wr_ev & ~cd;
  assign tx_data      = din;
  assign rx_pop       = rd_ev & ~cd;
  assign cfg_two_stop = cfg.two_stop;
  assign cfg_even_par = cfg.even;
  assign cfg_par_en   = cfg.par_en;
  assign cfg_crc_en   = cfg.crc_sel & ~cfg.par_en;
  assign cfg_blk_len  = cfg.blk_len;
  assign tx_en        = cfg.tx_en;
  assign rx_en        = cfg.rx_en;
  assign wake_mode    = cfg.wake_mode;
  assign wake_addr    = cfg.wake_addr;
  assign rts_n        = ~cfg.rts_on;
  assign p0           = cfg.p0;
  assign p1           = cfg.p1_route ? st_tx_pkt_done : cfg.p0;
  assign irq          = irq_q;
endmodule

// File: rtl/hbi_chk.sv
module hbi_chk
  import hbi_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             tx_push,
  input logic             rx_pop,
  input logic             dout_oe,
  input logic             soft_rst,
  input logic             err_clr,
  input logic             baud_tick,
  input logic             tx_en,
  input logic             rx_en,
  input logic             rts_n,
  input logic [BLK_W-1:0] cfg_blk_len,
  input logic             cfg_par_en,
  input logic             cfg_crc_en
);
  a_r1_deselected_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (!tx_push && !rx_pop && !dout_oe));
  a_r2_push_once: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push |=> !tx_push);
  a_r2_pop_once: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |=> !rx_pop);
  a_r4_parity_first: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_par_en |-> !cfg_crc_en);
  a_r7_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !soft_rst);
  a_r7_settings_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> (!tx_en && !rx_en && rts_n && cfg_blk_len == '0));
  a_r8_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr |=> !err_clr);
  a_r9_tick_width: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |=> !baud_tick);
endmodule

bind host_bus_if hbi_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cs_n        (cs_n),
  .tx_push     (tx_push),
  .rx_pop      (rx_pop),
  .dout_oe     (dout_oe),
  .soft_rst    (soft_rst),
  .err_clr     (err_clr),
  .baud_tick   (baud_tick),
  .tx_en       (tx_en),
  .rx_en       (rx_en),
  .rts_n       (rts_n),
  .cfg_blk_len (cfg_blk_len),
  .cfg_par_en  (cfg_par_en),
  .cfg_crc_en  (cfg_crc_en)
);

// File: tb/host_bus_if_test.sv
module host_bus_if_test;
  localparam int CLK_P = 10;
  localparam int NV    = 12;

  logic clk, rst_n, cs_n, cd, rd_n, wr_n;
  logic [7:0] din, dout, tx_data, rx_data, wake_addr;
  logic dout_oe, tx_push, rx_pop;
  logic st_crc_err, st_par_err, st_ovr_err, st_frm_err, st_tx_buf_empty;
  logic st_rx_full, st_rx_pkt_end, st_tx_idle, st_tx_pkt_done, st_wake_held;
  logic cfg_two_stop, cfg_even_par, cfg_par_en, cfg_crc_en;
  logic [5:0] cfg_blk_len;
  logic tx_en, rx_en, wake_mode, soft_rst, err_clr, baud_tick, rts_n, p0, p1, irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  host_bus_if uut (.*);

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  function automatic logic [23:0] snapv(input logic [7:0] wa, input logic [5:0] bl,
      input logic ts, input logic ev, input logic pe, input logic crc,
      input logic tx, input logic rx, input logic wm, input logic rtsn,
      input logic q0, input logic q1);
    return {wa, bl, ts, ev, pe, crc, tx, rx, wm, rtsn, q0, q1};
  endfunction

  function automatic logic [23:0] snap();
    return {wake_addr, cfg_blk_len, cfg_two_stop, cfg_even_par, cfg_par_en, cfg_crc_en,
            tx_en, rx_en, wake_mode, rts_n, p0, p1};
  endfunction

  // {requirement, command byte, expected settings}; st_tx_pkt_done is 1 while walked
  localparam logic [39:0] VEC [NV] = '{
    {8'd3,  8'h2C, snapv(8'h00,  0, 1,1,0,1, 0,0,0,1, 0,0)}, // R3 frame fields
    {8'd4,  8'h18, snapv(8'h00,  0, 0,0,1,0, 0,0,0,1, 0,0)}, // R4 parity over CRC
    {8'd3,  8'h45, snapv(8'h00,  5, 0,0,1,0, 0,0,0,1, 0,0)}, // R3 block length
    {8'd3,  8'h7F, snapv(8'h00, 63, 0,0,1,0, 0,0,0,1, 0,0)}, // R3 block length max
    {8'd6,  8'h8B, snapv(8'h00, 63, 0,0,1,0, 1,1,0,0, 0,0)}, // R6 control bits
    {8'd12, 8'hC3, snapv(8'h00, 63, 0,0,1,0, 1,1,0,0, 1,1)}, // R12 routed p1
    {8'd12, 8'hC0, snapv(8'h00, 63, 0,0,1,0, 1,1,0,0, 0,0)}, // R12 p1 follows p0
    {8'd5,  8'h84, snapv(8'h00, 63, 0,0,1,0, 0,0,1,1, 0,0)}, // R5 wakeup, addr pending
    {8'd5,  8'hC5, snapv(8'hC5, 63, 0,0,1,0, 0,0,1,1, 0,0)}, // R5 taken as address
    {8'd5,  8'h02, snapv(8'hC5, 63, 0,0,0,0, 0,0,1,1, 0,0)}, // R5 divider pending
    {8'd5,  8'hA0, snapv(8'hC5, 63, 0,0,0,0, 0,0,1,1, 0,0)}, // R5 taken as n, no reset
    {8'd7,  8'hA0, snapv(8'h00,  0, 0,0,0,0, 0,0,0,1, 0,0)}  // R7 internal reset
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic c, input logic [7:0] v);
    @(negedge clk);
    cs_n = 1'b0; cd = c; din = v; wr_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1; cs_n = 1'b1;
  endtask

  task automatic bus_read(input logic c, output logic [7:0] v);
    @(negedge clk);
    cs_n = 1'b0; cd = c; rd_n = 1'b0;
    @(negedge clk);
    v = dout;
    rd_n = 1'b1; cs_n = 1'b1;
  endtask

  task automatic measure(output int p);
    @(negedge clk);
    while (baud_tick !== 1'b1) @(negedge clk);
    p = 0;
    do begin
      @(negedge clk);
      p++;
    end while (baud_tick !== 1'b1);
  endtask

  task automatic clear_flags();
    {st_crc_err, st_par_err, st_ovr_err, st_frm_err, st_tx_buf_empty} = '0;
    {st_rx_full, st_rx_pkt_end, st_tx_idle, st_tx_pkt_done, st_wake_held} = '0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [7:0] v;
    int per;
    rst_n = 1'b0; cs_n = 1'b1; cd = 1'b0; rd_n = 1'b1; wr_n = 1'b1;
    din = '0; rx_data = '0;
    clear_flags();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R13 reset state
    check("R13 settings", snap(), snapv(8'h00, 0, 0,0,0,0, 0,0,0,1, 0,0));
    check("R13 pins", {dout_oe, tx_push, rx_pop, soft_rst, err_clr, irq}, 6'b000001);
    measure(per);
    check("R13 R9 default period", per, 2);

    // command table
    st_tx_pkt_done = 1'b1;
    for (int i = 0; i < NV; i++) begin
      bus_write(1'b1, VEC[i][31:24]);
      check($sformatf("R%0d vector %0d", VEC[i][39:32], i), snap(), VEC[i][23:0]);
    end
    check("R7 soft_rst high", soft_rst, 1'b1);
    @(negedge clk);
    check("R7 soft_rst cleared", soft_rst, 1'b0);

    // R8 error reset with other bits
    bus_write(1'b1, 8'h93);
    check("R8 err_clr high", err_clr, 1'b1);
    check("R8 enables applied", {tx_en, rx_en}, 2'b11);
    @(negedge clk);
    check("R8 err_clr cleared", err_clr, 1'b0);

    // R10 status alternation
    bus_write(1'b1, 8'hA0);
    clear_flags();
    st_crc_err = 1; st_ovr_err = 1; st_tx_buf_empty = 1; st_rx_pkt_end = 1;
    st_tx_idle = 1; st_wake_held = 1;
    rx_data = 8'h3C;
    bus_read(1'b1, v); check("R10 first status", v, 8'h55);
    bus_read(1'b1, v); check("R10 second status", v, 8'h8A);
    bus_read(1'b0, v); check("R2 data read", v, 8'h3C);
    bus_read(1'b1, v); check("R10 data read leaves order", v, 8'h55);
    @(negedge clk);
    cs_n = 0; cd = 1; rd_n = 0;
    repeat (3) @(negedge clk);
    v = dout; rd_n = 1; cs_n = 1;
    check("R2 R10 long read once", v, 8'h8A);
    bus_read(1'b1, v); check("R10 after long read", v, 8'h55);
    bus_write(1'b1, 8'hA0);
    bus_read(1'b1, v); check("R7 status order restarts", v, 8'h55);

    // R2 pop timing
    @(negedge clk);
    rx_data = 8'hE7; cs_n = 0; cd = 0; rd_n = 0;
    #1 check("R2 pop in first cycle", {rx_pop, dout_oe}, 2'b11);
    @(negedge clk);
    check("R2 pop single", rx_pop, 1'b0);
    check("R2 data on dout", dout, 8'hE7);
    rd_n = 1; cs_n = 1;

    // R2 push timing
    @(negedge clk);
    cs_n = 0; cd = 0; din = 8'h5A; wr_n = 0;
    #1 check("R2 push with data", {tx_push, tx_data}, {1'b1, 8'h5A});
    @(negedge clk);
    check("R2 push single", tx_push, 1'b0);
    wr_n = 1; cs_n = 1;

    // R1 invalid accesses
    @(negedge clk);
    cs_n = 0; cd = 1; din = 8'h8B; wr_n = 0; rd_n = 0;
    #1 check("R1 both strobes quiet", {tx_push, rx_pop, dout_oe}, 3'b000);
    @(negedge clk);
    wr_n = 1; rd_n = 1; cs_n = 1;
    check("R1 both strobes ignored", {tx_en, rx_en, rts_n}, 3'b001);
    @(negedge clk);
    cs_n = 1; cd = 1; din = 8'h8B; wr_n = 0;
    @(negedge clk);
    wr_n = 1;
    check("R1 deselected write ignored", {tx_en, rx_en, rts_n}, 3'b001);
    rd_n = 0;
    #1 check("R1 deselected read no drive", dout_oe, 1'b0);
    @(negedge clk);
    rd_n = 1;

    // R5 data traffic does not consume pending divider byte
    bus_write(1'b1, 8'h02);
    bus_write(1'b0, 8'h8B);
    bus_read(1'b1, v);
    bus_write(1'b1, 8'h02);
    check("R5 data write not a command", {tx_en, rx_en}, 2'b00);
    measure(per);
    check("R5 R9 n=2 P=2", per, 6);

    // R9 divider settings
    bus_write(1'b1, 8'h03);
    bus_write(1'b1, 8'h00);
    measure(per);
    check("R9 n=0 P=32", per, 32);
    bus_write(1'b1, 8'h02);
    bus_write(1'b1, 8'hFF);
    measure(per);
    check("R9 n=255 P=2", per, 512);

    // R11 interrupt sources and polarity
    bus_write(1'b1, 8'hA0);
    clear_flags();
    repeat (2) @(negedge clk);
    check("R11 idle active-low", irq, 1'b1);
    st_tx_buf_empty = 1; @(negedge clk);
    check("R11 tx empty", irq, 1'b0);
    st_tx_buf_empty = 0; st_rx_full = 1; @(negedge clk);
    check("R11 rx full", irq, 1'b0);
    st_rx_full = 0; st_rx_pkt_end = 1; @(negedge clk);
    check("R11 packet end", irq, 1'b0);
    st_rx_pkt_end = 0; st_crc_err = 1; st_tx_idle = 1; @(negedge clk);
    check("R11 other flags no request", irq, 1'b1);
    st_crc_err = 0; st_tx_idle = 0;
    // polarity change and request rise at the same edge
    @(negedge clk);
    cs_n = 0; cd = 1; din = 8'hC4; wr_n = 0; st_rx_full = 1;
    #1 check("R2 command write no push", tx_push, 1'b0);
    @(negedge clk);
    check("R11 old polarity new request", irq, 1'b0);
    wr_n = 1; cs_n = 1;
    @(negedge clk);
    check("R11 new polarity", irq, 1'b1);
    st_rx_full = 0; @(negedge clk);
    check("R11 active-high idle", irq, 1'b0);

    // R12 routed p1 follows the packet flag
    bus_write(1'b1, 8'hC2);
    st_tx_pkt_done = 0;
    #1 check("R12 p1 low", {p0, p1}, 2'b00);
    st_tx_pkt_done = 1;
    #1 check("R12 p1 high", {p0, p1}, 2'b01);

    finish_run();
  end
endmodule